// File: doc/BRIEF.md
# Dual-Channel Converter Serial Write Front End

This block is the digital front end of a two-channel 12-bit converter. A host writes 16-bit commands over a write-only serial link made of an active-low select, a serial clock and a serial data line. The block sees both the serial clock and the data through synchronizers in its own, much faster, system clock domain. Each command carries four control bits and a 12-bit code. They go to the input register of the channel that the command selects.

Each channel holds two register stages. A completed command only updates the input stage. A separate active-low load strobe copies both input stages into the output stages, so the two channels can change on the same cycle. Each channel's output stage gives its code together with its reference-buffer, gain and enable flags.

A command takes effect only when at least 16 serial clocks arrive while select is low. Clocks after the sixteenth are ignored. A command cut short by select rising is thrown away. One-cycle pulses report whether each command was accepted or discarded.

Top module: `dual_dac_frontend`

## Requirements
- R1: Serial data is sampled on each rising edge of the serial clock, most significant bit first. This works whether the clock idles low or idles high between commands.
- R2: While select (`cs_n_i`) is high, serial clock edges shift nothing in and cannot complete a command.
- R3: Command bit 15 picks the target channel: 0 writes channel A and 1 writes channel B. The other channel's registers do not change.
- R4: Field decoding: bit 14 set means the reference is buffered (`bufen`=1), bit 13 set means unity gain (`gain1x`=1), bit 12 set means the output is active (`active`=1, clear means shut down), and bits 11..0 are the code.
- R5: When select rises after 16 or more clocks, the first 16 bits are written into the selected input register and `frame_ok_o` pulses. Later bits are ignored.
- R6: When select rises after fewer than 16 clocks, `frame_abort_o` pulses and no input register changes.
- R7: While `load_n_i` is low, each output stage takes its input stage's value, so both channels update together. While it is high, the output stages hold.
- R8: After reset every register is zero, so both outputs show code 0 and are shut down.
- R9: `frame_ok_o` and `frame_abort_o` are single-cycle pulses, and at most one of them fires per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| load_n_i | input | 1 | Active-low load strobe, level sensitive |
| code_a_o | output | 12 | Channel A output code |
| bufen_a_o | output | 1 | Channel A reference buffered |
| gain1x_a_o | output | 1 | Channel A unity gain |
| active_a_o | output | 1 | Channel A enabled (0 = shut down) |
| code_b_o | output | 12 | Channel B output code |
| bufen_b_o | output | 1 | Channel B reference buffered |
| gain1x_b_o | output | 1 | Channel B unity gain |
| active_b_o | output | 1 | Channel B enabled (0 = shut down) |
| frame_ok_o | output | 1 | One-cycle pulse when a command is accepted |
| frame_abort_o | output | 1 | One-cycle pulse when a command is discarded |

## Verification
Some properties are checked by assertions on every cycle. The bit counter never passes 16 and is zero whenever select has been high. An input stage changes only on a commit addressed to its channel. An output stage follows its input stage while the strobe is low and holds while it is high. The outcome pulses never overlap or last two cycles. The decoding of fields and channel selection cannot be seen this way, nor can discarding of short commands, the ignoring of extra clocks, or operation with either clock idle level. Only the bench's scenarios show these, by comparing the output codes and flags after a load.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int CODE_W = 12;
    localparam int CFG_W  = 4;
    localparam int WORD_W = CODE_W + CFG_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    // bit positions inside a received word
    localparam int SEL_BIT  = WORD_W - 1;
    localparam int BUF_BIT  = WORD_W - 2;
    localparam int GAIN_BIT = WORD_W - 3;
    localparam int ACT_BIT  = WORD_W - 4;

    typedef struct packed {
        logic              bufen;
        logic              gain1x;
        logic              active;
        logic [CODE_W-1:0] code;
    } chan_cfg_t;

    typedef struct packed {
        logic      sel_b;
        chan_cfg_t cfg;
    } dac_cmd_t;

    function automatic dac_cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        dac_cmd_t c;
        c.sel_b      = w[SEL_BIT];
        c.cfg.bufen  = w[BUF_BIT];
        c.cfg.gain1x = w[GAIN_BIT];
        c.cfg.active = w[ACT_BIT];
        c.cfg.code   = w[CODE_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= RST_VAL;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dacfe_rx.sv
module dacfe_rx
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    output logic [WORD_W-1:0] word_o,
    output logic              frame_ok_o,
    output logic              frame_abort_o
);
    logic             cs_prev, sclk_prev;
    logic [CNT_W-1:0] bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic             sclk_rise, cs_rise;

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign cs_rise   = cs_n_s & ~cs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_n_s;
            sclk_prev <= sclk_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (cs_n_s) begin
            bit_cnt <= '0;
        end else if (sclk_rise && bit_cnt < CNT_W'(WORD_W)) begin
            shreg   <= {shreg[WORD_W-2:0], sdi_s};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_ok_o    <= 1'b0;
            frame_abort_o <= 1'b0;
        end else begin
            frame_ok_o    <= cs_rise && (bit_cnt == CNT_W'(WORD_W));
            frame_abort_o <= cs_rise && (bit_cnt != CNT_W'(WORD_W));
        end
    end

    assign word_o = shreg;

    assert_cnt_cap_R5: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(WORD_W));

    assert_idle_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_n_s && cs_prev) |-> (bit_cnt == '0));

    assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(frame_ok_o && frame_abort_o));

    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_ok_o || frame_abort_o) |=> !(frame_ok_o || frame_abort_o));
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan
    import dacfe_pkg::*;
#(
    parameter logic CH_SEL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  dac_cmd_t  cmd_i,
    input  logic      commit_i,
    input  logic      load_n_s,
    output chan_cfg_t out_o
);
    chan_cfg_t in_q, out_q;
    logic      hit;

    assign hit = commit_i && (cmd_i.sel_b == CH_SEL);

    always_ff @(posedge clk) begin
        if (rst)      in_q <= '0;
        else if (hit) in_q <= cmd_i.cfg;
    end

    always_ff @(posedge clk) begin
        if (rst)            out_q <= '0;
        else if (!load_n_s) out_q <= in_q;
    end

    assign out_o = out_q;

    assert_inreg_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(in_q));

    assert_out_follow_R7: assert property (@(posedge clk) disable iff (rst)
        !load_n_s |=> (out_q == $past(in_q)));

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
        load_n_s |=> $stable(out_q));
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
    import dacfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              load_n_i,
    output logic [CODE_W-1:0] code_a_o,
    output logic              bufen_a_o,
    output logic              gain1x_a_o,
    output logic              active_a_o,
    output logic [CODE_W-1:0] code_b_o,
    output logic              bufen_b_o,
    output logic              gain1x_b_o,
    output logic              active_b_o,
    output logic              frame_ok_o,
    output logic              frame_abort_o
);
    localparam int NCH = 2;

    logic              cs_n_s, sclk_s, sdi_s, load_n_s;
    logic [WORD_W-1:0] word;
    logic              ok_p, abort_p;
    dac_cmd_t          cmd;
    chan_cfg_t         ch_out [NCH];

    // select and strobe idle high; clock and data reset low
    dacfe_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync_ctl (
        .clk(clk), .rst(rst), .d_i({cs_n_i, load_n_i}), .q_o({cs_n_s, load_n_s}));

    dacfe_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_dat (
        .clk(clk), .rst(rst), .d_i({sclk_i, sdi_i}), .q_o({sclk_s, sdi_s}));

    dacfe_rx u_rx (
        .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
        .word_o(word), .frame_ok_o(ok_p), .frame_abort_o(abort_p));

    assign cmd = decode_cmd(word);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dacfe_chan #(.CH_SEL(1'(c))) u_ch (
            .clk(clk), .rst(rst), .cmd_i(cmd), .commit_i(ok_p),
            .load_n_s(load_n_s), .out_o(ch_out[c]));
    end

    assign code_a_o      = ch_out[0].code;
    assign bufen_a_o     = ch_out[0].bufen;
    assign gain1x_a_o    = ch_out[0].gain1x;
    assign active_a_o    = ch_out[0].active;
    assign code_b_o      = ch_out[1].code;
    assign bufen_b_o     = ch_out[1].bufen;
    assign gain1x_b_o    = ch_out[1].gain1x;
    assign active_b_o    = ch_out[1].active;
    assign frame_ok_o    = ok_p;
    assign frame_abort_o = abort_p;

    assert_reset_shutdown_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!active_a_o && !active_b_o && code_a_o == '0 && code_b_o == '0));
endmodule

// File: tb/dual_dac_frontend_tb.sv
module dual_dac_frontend_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, load_n = 1'b1;
    logic [11:0] code_a, code_b;
    logic bufen_a, gain_a, act_a, bufen_b, gain_b, act_b, fok, fab;

    int errors = 0;
    int checks = 0;
    int ok_cnt = 0, ab_cnt = 0, long_pulse = 0;
    logic fok_d = 1'b0, fab_d = 1'b0;

    localparam int HALF = 10;

    always #2.5 clk = ~clk;

    dual_dac_frontend dut_i (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi), .load_n_i(load_n),
        .code_a_o(code_a), .bufen_a_o(bufen_a), .gain1x_a_o(gain_a), .active_a_o(act_a),
        .code_b_o(code_b), .bufen_b_o(bufen_b), .gain1x_b_o(gain_b), .active_b_o(act_b),
        .frame_ok_o(fok), .frame_abort_o(fab));

    always @(posedge clk) begin
        if (fok) ok_cnt++;
        if (fab) ab_cnt++;
        if ((fok && fok_d) || (fab && fab_d) || (fok && fab)) long_pulse++;
        fok_d <= fok;
        fab_d <= fab;
    end

    function automatic logic [14:0] ch_a();
        return {bufen_a, gain_a, act_a, code_a};
    endfunction
    function automatic logic [14:0] ch_b();
        return {bufen_b, gain_b, act_b, code_b};
    endfunction

    task automatic check(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sends nbits of w, MSB first; idle_hi selects clock idling high
    task automatic spi_send(input logic [19:0] w, input int nbits, input bit idle_hi);
        sclk = idle_hi;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            sdi  = w[nbits-1-i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
        end
        if (!idle_hi) sclk = 1'b0;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(20);
    endtask

    task automatic do_load();
        load_n = 1'b0;
        wait_clk(10);
        load_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic t_reset();
        check(ch_a() == 15'd0, "R8 chan A reset", 32'(ch_a()), 0);
        check(ch_b() == 15'd0, "R8 chan B reset", 32'(ch_b()), 0);
        check(!act_a && !act_b, "R8 both shut down", {act_a, act_b}, 0);
    endtask

    task automatic t_write_a();
        int ok0 = ok_cnt;
        // A, buffered, 1x, active, code 0xA5C
        spi_send(20'h0_7A5C, 16, 0);
        check(ok_cnt == ok0 + 1, "R5 accept pulse", ok_cnt - ok0, 1);
        check(ch_a() == 15'd0, "R7 output held while load high", 32'(ch_a()), 0);
        do_load();
        check(ch_a() == {3'b111, 12'hA5C}, "R4 chan A fields", 32'(ch_a()), {3'b111, 12'hA5C});
        check(ch_b() == 15'd0, "R3 chan B untouched", 32'(ch_b()), 0);
    endtask

    task automatic t_write_b_mode11();
        // B, unbuffered, 2x, active, code 0x123, clock idling high
        spi_send(20'h0_9123, 16, 1);
        sclk = 1'b0;
        do_load();
        check(ch_b() == {3'b001, 12'h123}, "R1 R4 chan B mode 1,1", 32'(ch_b()), {3'b001, 12'h123});
        check(ch_a() == {3'b111, 12'hA5C}, "R3 chan A untouched", 32'(ch_a()), {3'b111, 12'hA5C});
    endtask

    task automatic t_short();
        int ab0 = ab_cnt, ok0 = ok_cnt;
        spi_send(20'h0_03FF, 10, 0);
        check(ab_cnt == ab0 + 1, "R6 abort pulse", ab_cnt - ab0, 1);
        check(ok_cnt == ok0, "R6 no accept", ok_cnt - ok0, 0);
        do_load();
        check(ch_a() == {3'b111, 12'hA5C}, "R6 chan A unchanged", 32'(ch_a()), {3'b111, 12'hA5C});
        check(ch_b() == {3'b001, 12'h123}, "R6 chan B unchanged", 32'(ch_b()), {3'b001, 12'h123});
    endtask

    task automatic t_extra();
        // first 16 bits: A, shutdown, 1x, code 0x0FF; 4 extra ones after
        spi_send({16'h20FF, 4'hF}, 20, 0);
        do_load();
        check(ch_a() == {3'b010, 12'h0FF}, "R5 extra clocks ignored", 32'(ch_a()), {3'b010, 12'h0FF});
    endtask

    task automatic t_cs_high();
        int ok0 = ok_cnt, ab0 = ab_cnt;
        cs_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            sdi = 1'b1; sclk = 1'b1; wait_clk(HALF);
            sclk = 1'b0; wait_clk(HALF);
        end
        check(ok_cnt == ok0 && ab_cnt == ab0, "R2 no outcome with select high", ok_cnt - ok0, 0);
        // a 12-bit frame must still abort: no bits were carried over
        spi_send(20'h0_0FFF, 12, 0);
        check(ab_cnt == ab0 + 1, "R2 no carried-over bits", ab_cnt - ab0, 1);
        do_load();
        check(ch_a() == {3'b010, 12'h0FF}, "R2 chan A unchanged", 32'(ch_a()), {3'b010, 12'h0FF});
    endtask

    task automatic t_together();
        bit seen = 0;
        spi_send(20'h0_5321, 16, 0);
        spi_send(20'h0_D654, 16, 0);
        load_n = 1'b0;
        for (int i = 0; i < 12 && !seen; i++) begin
            wait_clk(1);
            if (code_a == 12'h321) begin
                seen = 1;
                check(code_b == 12'h654, "R7 both change on one cycle", code_b, 12'h654);
            end
        end
        check(seen, "R7 load transfers A", code_a, 12'h321);
        wait_clk(2);
        // load held low: a new frame passes straight through
        spi_send(20'h0_1777, 16, 0);
        check(ch_a() == {3'b001, 12'h777}, "R7 transparent while load low", 32'(ch_a()), {3'b001, 12'h777});
        load_n = 1'b1;
        wait_clk(10);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        t_reset();
        t_write_a();
        t_write_b_mode11();
        t_short();
        t_extra();
        t_cs_high();
        t_together();
        check(long_pulse == 0, "R9 pulses single cycle and exclusive", long_pulse, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule